// File: doc/BRIEF.md
# Power-Mode and Clock-Select Controller

This controller decides how a small processor core is clocked. A configuration port sets two things: a doze-enable bit and a two-bit source request. The source request picks one of three clock sources: primary, secondary low-speed, or internal. The block watches a ready flag from each source. When software asks for a new source and that source is ready, the block moves the system clock mux to it. When the source is not yet ready, the block holds the request as pending and completes the switch later.

A one-cycle sleep strobe stands in for the processor's sleep instruction. When it arrives, the block samples the doze-enable bit. If the bit is set, the block gates only the CPU clock and keeps the peripherals running. If the bit is clear, it stops every clock. A wake event brings the block back to full operation. The current state is always visible as a three-bit mode code together with a pending-switch flag.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in mode 0 (run on primary). The mux select is 3'b001, both clock enables are 1, and the pending flag is 0.
- R2: The request field decodes as follows: 00 is primary, 01 is secondary, and both 10 and 11 are internal. The mux select is one-hot, with bit 0 for primary, bit 1 for secondary and bit 2 for internal. Mode codes 0, 1 and 2 are run on primary, secondary and internal. Codes 4, 5 and 6 are doze on the same three sources. Code 7 is sleep.
- R3: In every run mode the CPU and peripheral clock enables are both 1. A configuration write in a run mode never leaves run mode, whatever the doze-enable bit holds.
- R4: A write whose requested source is ready at the write edge switches the mux at that edge. The pending flag stays 0.
- R5: A write naming a source that is not ready keeps the current source and raises the pending flag. The switch happens at the first clock edge where that source's ready flag is 1, and the pending flag then clears.
- R6: A sleep strobe in run mode with doze-enable 1 enters the doze mode of the active source. The CPU enable goes to 0 and the peripheral enable stays 1. Source switches still complete while in doze.
- R7: A sleep strobe in run mode with doze-enable 0 enters mode 7. In mode 7 the mux select is 3'b000 and both enables are 0.
- R8: The doze-enable value used is the one held before the strobe's edge. A write in the same cycle as the strobe, or any later write, does not change the mode entered.
- R9: A wake event in a doze mode or in sleep returns the block to the run mode of the active source, with the CPU enable at 1.
- R10: A wake event in a run mode has no effect. A sleep strobe in a doze mode or in sleep has no effect.
- R11: In sleep no source switch completes, but a write is recorded as pending. After wake, the switch completes at the first edge where the block is running and the target source is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idle_en | input | 1 | Doze-enable value to write |
| cfg_src_sel | input | 2 | Source request to write |
| sleep_req | input | 1 | Sleep strobe, one cycle |
| wake_evt | input | 1 | Wake event |
| src_ready | input | 3 | Ready flags: bit 0 primary, bit 1 secondary, bit 2 internal |
| sys_clk_sel | output | 3 | One-hot system clock mux select, all zero in sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pwr_mode | output | 3 | Current mode code |
| sw_pending | output | 1 | Source switch requested but not yet done |

## Verification
The bench targets these corner cases:

- **Late-ready source.** The bench holds a requested source unready for several cycles, then raises its ready flag. A design that switches early, or that forgets the request, shows the wrong mux select or a stuck pending flag.
- **Write in the strobe cycle.** The bench writes doze-enable in the same cycle as a sleep strobe. A design that samples the new value enters doze instead of sleep.
- **Write during sleep.** The bench issues a source write while the block sleeps. A design that switches anyway drives a select while it should be dark.
- **Ignored strobes.** The bench sends a wake in a run mode and repeated sleep strobes in a low-power mode. A design that reacts shows an unexpected mode code.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int MODE_W  = SRC_W + 1;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [MODE_W-1:0] mode_t;

    // low-power level of the core
    typedef enum logic [1:0] {
        LP_ACTIVE = 2'd0,
        LP_DOZE   = 2'd1,
        LP_SLEEP  = 2'd2
    } lp_e;

    localparam mode_t MODE_SLEEP = {MODE_W{1'b1}};

    // request field to source index: 00 primary, 01 secondary, 1x internal
    function automatic src_t sel_to_src(sel_t s);
        if (s[1])      return src_t'(2);
        else if (s[0]) return src_t'(1);
        else           return src_t'(0);
    endfunction
endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic idle_in,
    input  sel_t sel_in,
    output logic idle_q,
    output sel_t sel_q
);
    typedef struct packed {
        logic idle;
        sel_t sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.idle = idle_in;
            cfg_d.sel  = sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign idle_q = cfg_q.idle;
    assign sel_q  = cfg_q.sel;
endmodule

// File: rtl/pmc_src_track.sv
module pmc_src_track
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  sel_t               sel_in,
    input  sel_t               sel_q,
    input  logic               switch_ok,
    input  logic [NUM_SRC-1:0] rdy,
    output src_t               act,
    output logic               pend
);
    typedef struct packed {
        src_t act;
        logic pend;
    } trk_t;

    trk_t trk_d, trk_q;
    src_t target;
    logic tgt_rdy;

    always_comb begin
        // a write in this cycle overrides the stored request
        target  = we ? sel_to_src(sel_in) : sel_to_src(sel_q);
        tgt_rdy = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (target == src_t'(i)) tgt_rdy = rdy[i];
        end
        trk_d = trk_q;
        if (switch_ok && tgt_rdy) trk_d.act = target;
        trk_d.pend = (target != trk_d.act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign act  = trk_q.act;
    assign pend = trk_q.pend;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake,
    input  logic idle_q,
    output lp_e  lp
);
    typedef struct packed {
        lp_e lp;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.lp)
            LP_ACTIVE: if (sleep_req) fsm_d.lp = idle_q ? LP_DOZE : LP_SLEEP;
            LP_DOZE,
            LP_SLEEP:  if (wake) fsm_d.lp = LP_ACTIVE;
            default:   fsm_d.lp = LP_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{lp: LP_ACTIVE};
        else        fsm_q <= fsm_d;
    end

    assign lp = fsm_q.lp;
endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
    import pmc_pkg::*;
(
    input  lp_e                lp,
    input  src_t               act,
    output logic [NUM_SRC-1:0] src_oh,
    output logic               cpu_en,
    output logic               per_en,
    output mode_t              mode
);
    logic dark;
    assign dark = (lp == LP_SLEEP);

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_oh
            assign src_oh[g] = !dark && (act == src_t'(g));
        end
    endgenerate

    assign cpu_en = (lp == LP_ACTIVE);
    assign per_en = !dark;
    assign mode   = dark ? MODE_SLEEP : {lp == LP_DOZE, act};
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_idle_en,
    input  logic [1:0]  cfg_src_sel,
    input  logic        sleep_req,
    input  logic        wake_evt,
    input  logic [2:0]  src_ready,
    output logic [2:0]  sys_clk_sel,
    output logic        cpu_clk_en,
    output logic        per_clk_en,
    output logic [2:0]  pwr_mode,
    output logic        sw_pending
);
    logic idle_q;
    sel_t sel_q;
    src_t act;
    lp_e  lp;

    pmc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .idle_in (cfg_idle_en),
        .sel_in  (cfg_src_sel),
        .idle_q  (idle_q),
        .sel_q   (sel_q)
    );

    pmc_src_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel_in    (cfg_src_sel),
        .sel_q     (sel_q),
        .switch_ok (lp != LP_SLEEP),
        .rdy       (src_ready),
        .act       (act),
        .pend      (sw_pending)
    );

    pmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake      (wake_evt),
        .idle_q    (idle_q),
        .lp        (lp)
    );

    pmc_out_dec u_dec (
        .lp     (lp),
        .act    (act),
        .src_oh (sys_clk_sel),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en),
        .mode   (pwr_mode)
    );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       wake_evt,
    input logic [2:0] sys_clk_sel,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic [2:0] pwr_mode,
    input logic       sw_pending
);
    assert_cpu_needs_per_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> per_clk_en);

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        per_clk_en |-> ($countones(sys_clk_sel) == 1));

    assert_sleep_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 3'd7) |-> (sys_clk_sel == 3'b000 && !per_clk_en && !cpu_clk_en));

    assert_lowpower_from_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_mode[2]) |-> $past(sleep_req));

    assert_run_stays_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_mode[2] && !sleep_req) |=> !pwr_mode[2]);

    assert_wake_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode[2] && wake_evt) |=> (!pwr_mode[2] && cpu_clk_en));

    assert_pending_holds_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_pending) |-> $stable(sys_clk_sel));
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .wake_evt    (wake_evt),
    .sys_clk_sel (sys_clk_sel),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .pwr_mode    (pwr_mode),
    .sw_pending  (sw_pending)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_idle_en = 1'b0;
    logic [1:0] cfg_src_sel = 2'b00;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic [2:0] src_ready = 3'b111;
    logic [2:0] sys_clk_sel;
    logic       cpu_clk_en;
    logic       per_clk_en;
    logic [2:0] pwr_mode;
    logic       sw_pending;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_idle_en (cfg_idle_en),
        .cfg_src_sel (cfg_src_sel),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .src_ready   (src_ready),
        .sys_clk_sel (sys_clk_sel),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .pwr_mode    (pwr_mode),
        .sw_pending  (sw_pending)
    );

    typedef struct {
        logic [2:0] mode;
        logic [2:0] sel;
        logic       cpu;
        logic       per;
        logic       pend;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state: lp 0 run, 1 doze, 2 sleep
    int m_lp = 0;
    int m_act = 0;
    logic [1:0] m_sel = 2'b00;
    bit m_idle = 0;

    function automatic int dec(logic [1:0] s);
        return s[1] ? 2 : (s[0] ? 1 : 0);
    endfunction

    function automatic exp_t expect_now(string tag);
        exp_t e;
        e.mode = (m_lp == 2) ? 3'd7 : 3'((m_lp == 1 ? 4 : 0) + m_act);
        e.sel  = (m_lp == 2) ? 3'b000 : 3'(1 << m_act);
        e.cpu  = (m_lp == 0);
        e.per  = (m_lp != 2);
        e.pend = (dec(m_sel) != m_act);
        e.tag  = tag;
        return e;
    endfunction

    task automatic step(input bit we, input bit idl, input logic [1:0] sel,
                        input bit slp, input bit wk, input logic [2:0] rdy,
                        input string tag);
        int tgt;
        @(negedge clk);
        cfg_we = we; cfg_idle_en = idl; cfg_src_sel = sel;
        sleep_req = slp; wake_evt = wk; src_ready = rdy;
        tgt = we ? dec(sel) : dec(m_sel);
        if (m_lp != 2 && rdy[tgt]) m_act = tgt;
        if (m_lp == 0 && slp)      m_lp = m_idle ? 1 : 2;
        else if (m_lp != 0 && wk)  m_lp = 0;
        if (we) begin m_sel = sel; m_idle = idl; end
        q.push_back(expect_now(tag));
    endtask

    // monitor: compares one expected item after each edge that follows a push
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (pwr_mode !== e.mode || sys_clk_sel !== e.sel || cpu_clk_en !== e.cpu ||
                    per_clk_en !== e.per || sw_pending !== e.pend) begin
                    n_bad++;
                    $display("FAIL %s: actual mode=%0d sel=%b cpu=%b per=%b pend=%b expected mode=%0d sel=%b cpu=%b per=%b pend=%b",
                             e.tag, pwr_mode, sys_clk_sel, cpu_clk_en, per_clk_en, sw_pending,
                             e.mode, e.sel, e.cpu, e.per, e.pend);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 2'b00, 0, 0, 3'b111, "R1");
        // R4 / R2 immediate switches, all codes of the request field
        step(1, 0, 2'b01, 0, 0, 3'b111, "R4");
        step(1, 0, 2'b10, 0, 0, 3'b111, "R2");
        step(1, 0, 2'b11, 0, 0, 3'b111, "R2");
        step(1, 0, 2'b00, 0, 0, 3'b111, "R4");
        // R5 target not ready, then ready
        step(1, 0, 2'b01, 0, 0, 3'b101, "R5");
        step(0, 0, 2'b00, 0, 0, 3'b101, "R5");
        step(0, 0, 2'b00, 0, 0, 3'b001, "R5");
        step(0, 0, 2'b00, 0, 0, 3'b010, "R5");
        // R3 doze-enable write in run leaves run mode alone
        step(1, 1, 2'b01, 0, 0, 3'b111, "R3");
        // R10 wake in run ignored
        step(0, 0, 2'b00, 0, 1, 3'b111, "R10");
        // R6 enter doze on secondary
        step(0, 0, 2'b00, 1, 0, 3'b111, "R6");
        step(0, 0, 2'b00, 1, 0, 3'b111, "R10");
        // R8 clearing doze-enable after entry changes nothing
        step(1, 0, 2'b01, 0, 0, 3'b111, "R8");
        // R9 wake from doze
        step(0, 0, 2'b00, 0, 1, 3'b111, "R9");
        // R8 same-cycle write does not count: old value 0 gives sleep
        step(1, 1, 2'b01, 1, 0, 3'b111, "R8");
        step(0, 0, 2'b00, 0, 0, 3'b111, "R7");
        // R11 write during sleep stays pending
        step(1, 1, 2'b10, 0, 0, 3'b111, "R11");
        step(0, 0, 2'b00, 1, 0, 3'b111, "R10");
        step(0, 0, 2'b00, 0, 1, 3'b011, "R9");
        step(0, 0, 2'b00, 0, 0, 3'b011, "R11");
        step(0, 0, 2'b00, 0, 0, 3'b100, "R11");
        // R6 doze on internal, switch while dozing
        step(0, 0, 2'b00, 1, 0, 3'b111, "R6");
        step(1, 1, 2'b00, 0, 0, 3'b111, "R6");
        step(0, 0, 2'b00, 0, 1, 3'b111, "R9");
        step(0, 0, 2'b00, 0, 0, 3'b111, "R3");
        @(negedge clk);
        cfg_we = 0; sleep_req = 0; wake_evt = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule